// File: doc/BRIEF.md
# MDIO Management Master with Continuous Scan

This block is the master side of a two-wire PHY management link. It generates the management clock (MDC) from the system clock with a selectable divide ratio. It also drives and releases the bidirectional data line (MDIO) to read one 16-bit register of one PHY. Software programs a PHY address and a register address, picks a clock ratio, and then issues a command. The command runs either a single read or a continuous scan. A scan re-reads the same register back to back until software withdraws the scan bit.

Three read-only indicators report progress: busy, scanning and result-not-valid. The read-data output holds the most recent completed result. It is marked not valid from the moment a command is accepted until the first result of that command lands. A level-sensitive management reset aborts any frame in flight and returns the block to its idle state.

Top module: `mdio_scan_master`

## Requirements
- R1: A command write with bit 0 set (bit 1 clear) while idle runs exactly one read frame. `ind_busy` and `ind_notvalid` read 1 from the cycle after the write. `ind_busy` drops after the last data bit. At that point `ind_notvalid` reads 0 and `rd_data` holds the received word.
- R2: Each frame starts with 32 ones on MDIO, then start bits 0,1, read opcode 1,0, the 5-bit PHY address and the 5-bit register address, each field MSB first. The master drives all 46 of these bits with `mdio_oe` high.
- R3: An address write takes the PHY address from `addr_wdata[12:8]` and the register address from `addr_wdata[4:0]`. All other bits are ignored.
- R4: `cfg_clksel` values 0..7 select MDC periods of 4, 4, 6, 8, 10, 14, 20 and 28 system clocks. MDC is high for half the period and low for half. The value is captured when a command is accepted.
- R5: For the two turnaround bit times and the 16 data bit times, `mdio_oe` is low. Data bits are sampled at MDC rising edges, MSB first.
- R6: `mdio_o` and `mdio_oe` change only when MDC falls; they are stable while MDC is high. When not busy, MDC and `mdio_oe` are low.
- R7: A command write with bit 1 set while idle starts back-to-back frames, and bit 1 wins over bit 0. `ind_scanning` reads 1 during the scan. `rd_data` is updated after every frame, and `ind_notvalid` clears at the first completed frame.
- R8: A command write with bit 1 clear during a scan drops `ind_scanning` in the next cycle. The frame in progress finishes, `ind_busy` then drops, and no further frame starts.
- R9: While busy, address writes, start commands and `cfg_clksel` changes have no effect on the frame in progress. After that frame, no new frame starts, and the address in use is unchanged.
- R10: Asynchronous reset, and `cfg_mgmt_rst` held high, both give the idle state: `ind_busy`=0, `ind_scanning`=0, `ind_notvalid`=1, `rd_data`=0, MDC=0, `mdio_oe`=0. Commands written while `cfg_mgmt_rst` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 2 | Bit 0 single read, bit 1 continuous scan |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | 16 | Bits 12:8 PHY address, bits 4:0 register address |
| cfg_clksel | input | 3 | MDC divide ratio select |
| cfg_mgmt_rst | input | 1 | Management block reset, level |
| mdio_i | input | 1 | MDIO input from pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| ind_busy | output | 1 | A frame is in progress or scheduled |
| ind_scanning | output | 1 | Continuous scan is active |
| ind_notvalid | output | 1 | `rd_data` is not yet a fresh result |
| rd_data | output | 16 | Last completed read result |

## Verification
A bit index that slips inside the frame engine shows at the PHY side within one MDC period. It appears as a header bit in the wrong place, an early or late release of `mdio_oe`, or a result word shifted by one. Each of these is flagged when that frame ends. A wrong divider limit shows as a wrong MDC period at the very next rising edge. A scan or busy flag that is wrong shows as an extra or missing frame. It also shows as an indicator that stays set for hundreds of cycles after the point where the frame count says the block must be idle.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int AW     = 5;   // PHY and register address width
  localparam int SEL_W  = 3;   // clock-select field width
  localparam int HALF_W = 4;   // width of a half-period count

  typedef struct packed {
    logic [AW-1:0] phy;
    logic [AW-1:0] regad;
  } mgmt_addr_t;

  // Half of the MDC period, in system clocks, for each select value.
  function automatic logic [HALF_W-1:0] half_of_sel(input logic [SEL_W-1:0] sel);
    logic [HALF_W-1:0] h;
    case (sel)
      3'd0, 3'd1: h = 4'd2;
      3'd2:       h = 4'd3;
      3'd3:       h = 4'd4;
      3'd4:       h = 4'd5;
      3'd5:       h = 4'd7;
      3'd6:       h = 4'd10;
      default:    h = 4'd14;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise_tick,
  output logic              fall_tick
);

  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              mdc_q, mdc_d;
  logic [HALF_W-1:0] lim;
  logic              wrap;

  assign lim  = half - HALF_W'(1);
  assign wrap = run && !srst && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (srst || !run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap &&  mdc_q;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              start,
  input  mgmt_addr_t        addr,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);

  localparam int HDR_LEN   = PRE_LEN + 4 + 2 * AW;
  localparam int FRAME_LEN = HDR_LEN + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_LEN);
  localparam logic [IDX_W-1:0] DAT_BEG  = IDX_W'(HDR_LEN + 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [HDR_LEN-1:0] hdr_msb, hdr_lsb;
  logic               act_q, act_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [DATA_W-1:0]  rx_q, rx_d;

  // Header: preamble, start 01, read opcode 10, PHY address, register address
  assign hdr_msb = {{PRE_LEN{1'b1}}, 4'b0110, addr.phy, addr.regad};

  for (genvar g = 0; g < HDR_LEN; g++) begin : g_rev
    assign hdr_lsb[g] = hdr_msb[HDR_LEN-1-g];
  end

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    rx_d  = rx_q;
    done  = 1'b0;
    if (srst) begin
      act_d = 1'b0;
      idx_d = '0;
      rx_d  = '0;
    end else if (start && !act_q) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (act_q) begin
      if (rise_tick && (idx_q >= DAT_BEG)) begin
        rx_d = {rx_q[DATA_W-2:0], mdio_i};
      end
      if (fall_tick) begin
        if (idx_q == LAST_IDX) begin
          act_d = 1'b0;
          done  = 1'b1;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      rx_q  <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      rx_q  <= rx_d;
    end
  end

  assign active  = act_q;
  assign mdio_oe = act_q && (idx_q < HDR_END);
  assign mdio_o  = mdio_oe ? hdr_lsb[idx_q] : 1'b1;
  assign rx_data = rx_q;

endmodule

// File: rtl/mdio_scan_master.sv
module mdio_scan_master
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [1:0]        cmd_wdata,
  input  logic              addr_we,
  input  logic [15:0]       addr_wdata,
  input  logic [SEL_W-1:0]  cfg_clksel,
  input  logic              cfg_mgmt_rst,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              ind_busy,
  output logic              ind_scanning,
  output logic              ind_notvalid,
  output logic [DATA_W-1:0] rd_data
);

  logic              busy_q, busy_d;
  logic              scan_q, scan_d;
  logic              nv_q, nv_d;
  logic              start_q, start_d;
  mgmt_addr_t        addr_q, addr_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic              eng_active, eng_done, rise_tick, fall_tick;
  logic [DATA_W-1:0] eng_rx;
  logic              accept, stop_req;

  assign accept   = cmd_we && !busy_q && (cmd_wdata != 2'b00);
  assign stop_req = cmd_we && busy_q && scan_q && !cmd_wdata[1];

  always_comb begin
    busy_d  = busy_q;
    scan_d  = scan_q;
    nv_d    = nv_q;
    start_d = 1'b0;
    addr_d  = addr_q;
    half_d  = half_q;
    rdata_d = rdata_q;
    if (cfg_mgmt_rst) begin
      busy_d  = 1'b0;
      scan_d  = 1'b0;
      nv_d    = 1'b1;
      rdata_d = '0;
    end else begin
      if (addr_we && !busy_q) begin
        addr_d.phy   = addr_wdata[12:8];
        addr_d.regad = addr_wdata[4:0];
      end
      if (accept) begin
        busy_d  = 1'b1;
        scan_d  = cmd_wdata[1];
        nv_d    = 1'b1;
        start_d = 1'b1;
        half_d  = half_of_sel(cfg_clksel);
      end
      if (stop_req) begin
        scan_d = 1'b0;
      end
      if (eng_done) begin
        rdata_d = eng_rx;
        nv_d    = 1'b0;
        if (scan_q && !stop_req) begin
          start_d = 1'b1;
        end else begin
          busy_d = 1'b0;
          scan_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      scan_q  <= 1'b0;
      nv_q    <= 1'b1;
      start_q <= 1'b0;
      addr_q  <= '0;
      half_q  <= 4'd2;
      rdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      scan_q  <= scan_d;
      nv_q    <= nv_d;
      start_q <= start_d;
      addr_q  <= addr_d;
      half_q  <= half_d;
      rdata_q <= rdata_d;
    end
  end

  mdio_mdc_gen u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (cfg_mgmt_rst),
    .run       (eng_active),
    .half      (half_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (cfg_mgmt_rst),
    .start     (start_q),
    .addr      (addr_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .active    (eng_active),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (eng_done),
    .rx_data   (eng_rx)
  );

  assign ind_busy     = busy_q;
  assign ind_scanning = scan_q;
  assign ind_notvalid = nv_q;
  assign rd_data      = rdata_q;

endmodule

// File: rtl/mdio_scan_master_chk.sv
module mdio_scan_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_mgmt_rst,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              ind_busy,
  input logic              ind_scanning,
  input logic              ind_notvalid,
  input logic [DATA_W-1:0] rd_data
);

  assert_scan_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ind_scanning |-> ind_busy);

  assert_idle_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_busy |-> (!mdc && !mdio_oe));

  assert_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_result_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ind_busy && $past(ind_busy) && !$past(cfg_mgmt_rst) && !cfg_mgmt_rst)
      |-> !ind_notvalid);

  assert_no_late_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_busy && !ind_scanning && !cfg_mgmt_rst) |=> !ind_scanning);

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mgmt_rst |=> (!ind_busy && !ind_scanning && ind_notvalid && !mdc
                      && !mdio_oe && (rd_data == '0)));

endmodule

bind mdio_scan_master mdio_scan_master_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/mdio_scan_master_tb_top.sv
`timescale 1ns/1ps
module mdio_scan_master_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we;
  logic [1:0]  cmd_wdata;
  logic        addr_we;
  logic [15:0] addr_wdata;
  logic [2:0]  cfg_clksel;
  logic        cfg_mgmt_rst;
  logic        mdio_i;
  logic        mdc, mdio_o, mdio_oe;
  logic        ind_busy, ind_scanning, ind_notvalid;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  mdio_scan_master dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .addr_we(addr_we), .addr_wdata(addr_wdata), .cfg_clksel(cfg_clksel),
    .cfg_mgmt_rst(cfg_mgmt_rst), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .ind_busy(ind_busy), .ind_scanning(ind_scanning),
    .ind_notvalid(ind_notvalid), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ratio(input int sel);
    case (sel)
      0, 1: return 4;
      2: return 6;
      3: return 8;
      4: return 10;
      5: return 14;
      6: return 20;
      default: return 28;
    endcase
  endfunction

  function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] r, input int f);
    return {3'b101, p, r, 3'(f)};
  endfunction

  // PHY model: checks the frame header and turnaround, measures MDC, returns data
  int pos = 0, frames = 0, cyc = 0, exp_n = 4;
  bit hdr_bad = 0, ta_bad = 0, per_bad = 0;
  logic mdc_prev = 1'b0;
  logic [4:0] cap_phy = '0, cap_reg = '0, last_phy = '0, last_reg = '0;
  logic [15:0] cur_resp = '0;
  logic expb;

  always @(negedge clk) begin
    if (!rst_n || cfg_mgmt_rst) begin
      pos = 0; cyc = 0; hdr_bad = 0; ta_bad = 0; per_bad = 0;
      mdc_prev = 1'b0; mdio_i = 1'b1;
    end else begin
      cyc++;
      if (mdc && !mdc_prev) begin
        if (pos != 0 && cyc != exp_n) per_bad = 1;
        cyc = 0;
        if (pos < 46) begin
          if (!mdio_oe) hdr_bad = 1;
          if (pos < 36) begin
            expb = (pos < 32) ? 1'b1 : (pos == 32) ? 1'b0 : (pos == 33) ? 1'b1 :
                   (pos == 34) ? 1'b1 : 1'b0;
            if (mdio_o !== expb) hdr_bad = 1;
          end else if (pos < 41) cap_phy = {cap_phy[3:0], mdio_o};
          else cap_reg = {cap_reg[3:0], mdio_o};
          if (pos == 45) cur_resp = resp(cap_phy, cap_reg, frames);
        end else if (mdio_oe) ta_bad = 1;
        if (pos == 63) begin
          chk(!hdr_bad, "R2", "frame header", hdr_bad, 0);
          chk(!ta_bad, "R5", "turnaround and data release", ta_bad, 0);
          chk(!per_bad, "R4", "MDC period", cyc, exp_n);
          hdr_bad = 0; ta_bad = 0; per_bad = 0;
          last_phy = cap_phy; last_reg = cap_reg;
          frames++;
          pos = 0;
        end else pos++;
      end
      mdio_i = (pos >= 48) ? cur_resp[63-pos] : 1'b1;
      mdc_prev = mdc;
    end
  end

  task automatic wr_addr(input logic [4:0] p, input logic [4:0] r);
    @(negedge clk); addr_we = 1'b1; addr_wdata = {3'b111, p, 3'b111, r};
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic wr_cmd(input logic [1:0] v);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (ind_busy) @(negedge clk);
  endtask

  task automatic wait_pos(input int p);
    while (pos != p) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int f0;
    logic [4:0] p, r;
    rst_n = 1'b0; cmd_we = 1'b0; cmd_wdata = '0; addr_we = 1'b0; addr_wdata = '0;
    cfg_clksel = '0; cfg_mgmt_rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!ind_busy, "R10", "busy after reset", ind_busy, 0);
    chk(!ind_scanning, "R10", "scanning after reset", ind_scanning, 0);
    chk(ind_notvalid, "R10", "notvalid after reset", ind_notvalid, 1);
    chk(!mdc && !mdio_oe, "R10", "mdc/oe after reset", {mdc, mdio_oe}, 0);
    chk(rd_data == 0, "R10", "rd_data after reset", rd_data, 0);

    // R1 R3 R4 R5: single read for every clock select
    for (int cs = 0; cs < 8; cs++) begin
      p = 5'(cs * 3 + 1); r = 5'(30 - cs * 3);
      cfg_clksel = 3'(cs); exp_n = ratio(cs);
      wr_addr(p, r);
      f0 = frames;
      wr_cmd(2'b01);
      chk(ind_busy && ind_notvalid && !ind_scanning, "R1", "indicators after start",
          {ind_busy, ind_notvalid, ind_scanning}, 3'b110);
      wait_idle();
      @(negedge clk);
      chk(frames == f0 + 1, "R1", "frames for single read", frames, f0 + 1);
      chk(last_phy == p, "R3", "PHY address on wire", last_phy, p);
      chk(last_reg == r, "R3", "register address on wire", last_reg, r);
      chk(rd_data == resp(p, r, f0), "R5", "read data", rd_data, resp(p, r, f0));
      chk(!ind_notvalid, "R1", "notvalid after completion", ind_notvalid, 0);
    end

    // R7: scan, both bits set
    cfg_clksel = 3'd1; exp_n = 4;
    wr_addr(5'd9, 5'd17);
    f0 = frames;
    wr_cmd(2'b11);
    chk(ind_scanning && ind_busy && ind_notvalid, "R7", "scan start indicators",
        {ind_scanning, ind_busy, ind_notvalid}, 3'b111);
    while (frames != f0 + 1) @(negedge clk);
    repeat (32) @(negedge clk);
    chk(rd_data == resp(9, 17, f0), "R7", "first scan result", rd_data, resp(9, 17, f0));
    chk(!ind_notvalid, "R7", "notvalid after first scan frame", ind_notvalid, 0);
    while (frames != f0 + 2) @(negedge clk);
    repeat (32) @(negedge clk);
    chk(rd_data == resp(9, 17, f0 + 1), "R7", "second scan result", rd_data,
        resp(9, 17, f0 + 1));
    chk(ind_busy && ind_scanning, "R7", "still scanning", {ind_busy, ind_scanning}, 3);

    // R8: stop scan mid-frame
    wait_pos(20);
    f0 = frames;
    wr_cmd(2'b00);
    chk(!ind_scanning && ind_busy, "R8", "scan dropped, frame continues",
        {ind_scanning, ind_busy}, 1);
    wait_idle();
    @(negedge clk);
    chk(frames == f0 + 1, "R8", "frames after stop", frames, f0 + 1);
    chk(rd_data == resp(9, 17, f0), "R8", "last scan result", rd_data, resp(9, 17, f0));
    repeat (400) @(negedge clk);
    chk(frames == f0 + 1 && !ind_busy, "R8", "no frame after stop", frames, f0 + 1);

    // R9: writes while busy are ignored
    cfg_clksel = 3'd0; exp_n = 4;
    wr_addr(5'd3, 5'd4);
    f0 = frames;
    wr_cmd(2'b01);
    wait_pos(10);
    wr_addr(5'd20, 5'd21);
    wr_cmd(2'b10);
    chk(!ind_scanning, "R9", "scan bit while busy", ind_scanning, 0);
    cfg_clksel = 3'd7;
    wr_cmd(2'b01);
    wait_idle();
    @(negedge clk);
    chk(frames == f0 + 1, "R9", "one frame only", frames, f0 + 1);
    chk(last_phy == 5'd3 && last_reg == 5'd4, "R9", "address kept during frame",
        {last_phy, last_reg}, {5'd3, 5'd4});
    repeat (400) @(negedge clk);
    chk(frames == f0 + 1 && !ind_busy, "R9", "no deferred start", frames, f0 + 1);
    exp_n = 28;
    wr_cmd(2'b01);
    wait_idle();
    @(negedge clk);
    chk(last_phy == 5'd3 && last_reg == 5'd4, "R9", "busy address write dropped",
        {last_phy, last_reg}, {5'd3, 5'd4});
    chk(rd_data == resp(3, 4, f0 + 1), "R9", "read after ignored writes", rd_data,
        resp(3, 4, f0 + 1));

    // R10: management reset mid-frame
    cfg_clksel = 3'd2; exp_n = 6;
    wr_cmd(2'b01);
    wait_pos(30);
    @(negedge clk) cfg_mgmt_rst = 1'b1;
    wr_cmd(2'b01);
    chk(!ind_busy && !ind_scanning && ind_notvalid, "R10", "indicators in soft reset",
        {ind_busy, ind_scanning, ind_notvalid}, 3'b001);
    chk(!mdc && !mdio_oe && rd_data == 0, "R10", "lines and data in soft reset",
        {mdc, mdio_oe, rd_data}, 0);
    @(negedge clk) cfg_mgmt_rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(!ind_busy, "R10", "command during soft reset ignored", ind_busy, 0);
    f0 = frames;
    wr_cmd(2'b01);
    wait_idle();
    @(negedge clk);
    chk(rd_data == resp(3, 4, f0), "R10", "read after soft reset", rd_data, resp(3, 4, f0));

    finish_run();
  end

endmodule